// File: doc/BRIEF.md
# SD Command Response Receiver and Checker

This block sits on the host side of an SD card link and handles the response the card sends back on the CMD line once a command has gone out. When `issue_i` is accepted, the block records what kind of response to expect, the index of the command just sent, and whether the index and CRC7 checks are wanted. It then watches the CMD line for the start bit, shifts in the whole frame and compares the fields.

A 2-bit kind code picks the response shape. It can be no response, a long 136-bit frame, a short 48-bit frame, or a short frame followed by a busy period on DAT0. The captured frame is presented on `rsp_o`. One `done_o` pulse marks the end of each transaction. Three sticky flags report an index mismatch, a CRC mismatch and a missing start bit. The flags hold until the next accepted issue.

Top module: `sd_rsp_rx`

## Requirements
- R1: After reset `done_o`, `idx_err_o`, `crc_err_o`, `tmo_err_o` and all of `rsp_o` are 0.
- R2: Kind code 00 (no response) samples no bits. `done_o` is high in the clock cycle right after the edge that accepts `issue_i`, with all flags 0 and `rsp_o` all zero.
- R3: For kind 10 or 11 the first 0 sampled on `cmd_line_i` is the start bit. It and the next 47 bits are stored MSB first, so the start bit lands in `rsp_o[47]` and `rsp_o[135:48]` stays 0. `done_o` pulses one clock after the edge that samples the last bit.
- R4: For kind 01, 136 bits are stored MSB first with the start bit in `rsp_o[135]`. The index flag is never set for this kind.
- R5: For a 48-bit kind with `idx_chk_i` set at issue, `rsp_o[45:40]` is compared with `cmd_idx_i`, and a difference sets `idx_err_o`. With `idx_chk_i` clear, `idx_err_o` stays 0.
- R6: The CRC7 uses x^7+x^3+1 and starts from zero. It is computed over `rsp_o[47:8]` for 48-bit kinds and over `rsp_o[127:8]` for kind 01, then compared with `rsp_o[7:1]`. A difference sets `crc_err_o` only if `crc_chk_i` was set at issue.
- R7: If none of the first 64 CMD samples after the issue is 0, `tmo_err_o` and `done_o` are raised after the 64th sample. A start bit at the 64th sample is still accepted.
- R8: For kind 11, after the frame `done_o` waits until DAT0 has been sampled low and then sampled high. It pulses in the cycle after that high sample.
- R9: `done_o` lasts one cycle. Flags and `rsp_o` hold until the next accepted issue. `issue_i` is ignored while a transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Command has been sent; start receiving |
| rsp_kind_i | input | 2 | Expected response: 00 none, 01 136-bit, 10 48-bit, 11 48-bit with busy |
| cmd_idx_i | input | 6 | Index of the issued command |
| idx_chk_i | input | 1 | Enable the index comparison |
| crc_chk_i | input | 1 | Enable the CRC7 comparison |
| cmd_line_i | input | 1 | Sampled CMD line |
| dat0_i | input | 1 | Sampled DAT0 line |
| done_o | output | 1 | One-cycle completion pulse |
| rsp_o | output | 136 | Captured response frame |
| idx_err_o | output | 1 | Index mismatch |
| crc_err_o | output | 1 | CRC7 mismatch |
| tmo_err_o | output | 1 | No start bit in time |

## Verification
The embedded properties assume that `cmd_line_i` and `dat0_i` are already synchronous to `clk` and settle between edges. They also assume that `issue_i` is a single-cycle pulse whose companion inputs are valid during that same cycle. The stimulus meets these assumptions by changing every input only on the falling edge and by dropping `issue_i` after one cycle. Any extra pulse it sends in the middle of a transaction is deliberate, and it is sent to confirm that the pulse is ignored.

// File: rtl/sd_rsp_rx.sv
module sd_rsp_rx #(
  parameter int TMO_CYCLES = 64,
  parameter int LONG_BITS  = 136,
  parameter int SHORT_BITS = 48,
  parameter int IDX_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_i,
  input  logic [1:0]           rsp_kind_i,
  input  logic [IDX_W-1:0]     cmd_idx_i,
  input  logic                 idx_chk_i,
  input  logic                 crc_chk_i,
  input  logic                 cmd_line_i,
  input  logic                 dat0_i,
  output logic                 done_o,
  output logic [LONG_BITS-1:0] rsp_o,
  output logic                 idx_err_o,
  output logic                 crc_err_o,
  output logic                 tmo_err_o
);
  localparam int CRC_W = 7;
  localparam int HDR_W = 8;
  localparam int CNT_W = $clog2(LONG_BITS + 1);
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SHIFT, S_CHECK, S_BUSY_LO, S_BUSY_HI} state_t;

  state_t           st;
  logic [1:0]       kind_q;
  logic [IDX_W-1:0] idx_q;
  logic             idx_en_q, crc_en_q;
  logic [CNT_W-1:0] nbits;
  logic [TMO_W-1:0] wcnt;
  logic [CRC_W-1:0] crc_q;

  wire             is_long   = (kind_q == 2'b01);
  wire [CNT_W-1:0] frame_len = is_long ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);
  wire [CNT_W-1:0] crc_lo    = is_long ? CNT_W'(HDR_W) : '0;
  wire [CNT_W-1:0] crc_hi    = frame_len - CNT_W'(HDR_W);
  wire             crc_win   = (nbits >= crc_lo) && (nbits < crc_hi);
  wire             fb        = cmd_line_i ^ crc_q[CRC_W-1];
  wire [CRC_W-1:0] crc_nx    = {crc_q[5:3], crc_q[2] ^ fb, crc_q[1:0], fb};
  wire             idx_bad   = !is_long && (rsp_o[SHORT_BITS-3 -: IDX_W] != idx_q);
  wire             crc_bad   = (crc_q != rsp_o[CRC_W:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind_q    <= '0;
      idx_q     <= '0;
      idx_en_q  <= 1'b0;
      crc_en_q  <= 1'b0;
      nbits     <= '0;
      wcnt      <= '0;
      crc_q     <= '0;
      rsp_o     <= '0;
      done_o    <= 1'b0;
      idx_err_o <= 1'b0;
      crc_err_o <= 1'b0;
      tmo_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (issue_i) begin
          kind_q    <= rsp_kind_i;
          idx_q     <= cmd_idx_i;
          idx_en_q  <= idx_chk_i;
          crc_en_q  <= crc_chk_i;
          nbits     <= '0;
          wcnt      <= '0;
          crc_q     <= '0;
          rsp_o     <= '0;
          idx_err_o <= 1'b0;
          crc_err_o <= 1'b0;
          tmo_err_o <= 1'b0;
          if (rsp_kind_i == 2'b00) done_o <= 1'b1;
          else                     st     <= S_WAIT;
        end
        S_WAIT: begin
          wcnt <= wcnt + 1'b1;
          if (!cmd_line_i) begin
            rsp_o <= {rsp_o[LONG_BITS-2:0], 1'b0};
            nbits <= CNT_W'(1);
            st    <= S_SHIFT;
          end else if (wcnt == TMO_W'(TMO_CYCLES - 1)) begin
            tmo_err_o <= 1'b1;
            done_o    <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_SHIFT: begin
          rsp_o <= {rsp_o[LONG_BITS-2:0], cmd_line_i};
          nbits <= nbits + 1'b1;
          if (crc_win) crc_q <= crc_nx;
          if (nbits == frame_len - CNT_W'(1)) st <= S_CHECK;
        end
        S_CHECK: begin
          idx_err_o <= idx_en_q && idx_bad;
          crc_err_o <= crc_en_q && crc_bad;
          if (kind_q == 2'b11) st <= S_BUSY_LO;
          else begin
            done_o <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_BUSY_LO: if (!dat0_i) st <= S_BUSY_HI;
        S_BUSY_HI: if (dat0_i) begin
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_none_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && issue_i && rsp_kind_i == 2'b00) |=> done_o);
  p_long_noidx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == 2'b01) |-> !idx_err_o);
  p_idx_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_en_q |-> !idx_err_o);
  p_crc_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_en_q |-> !crc_err_o);
  p_tmo_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err_o) |-> done_o);
  p_busy_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_q == 2'b11 && !tmo_err_o) |-> $past(dat0_i));
  p_ignore_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && issue_i) |=> $stable(kind_q));
endmodule

// File: tb/sd_rsp_rx_tb_top.sv
`timescale 1ns/1ps
module sd_rsp_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_i = 1'b0;
  logic [1:0] rsp_kind_i = 2'b00;
  logic [5:0] cmd_idx_i = '0;
  logic idx_chk_i = 1'b0, crc_chk_i = 1'b0;
  logic cmd_line_i = 1'b1, dat0_i = 1'b1;
  logic done_o, idx_err_o, crc_err_o, tmo_err_o;
  logic [135:0] rsp_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sd_rsp_rx dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .rsp_kind_i(rsp_kind_i),
    .cmd_idx_i(cmd_idx_i), .idx_chk_i(idx_chk_i), .crc_chk_i(crc_chk_i),
    .cmd_line_i(cmd_line_i), .dat0_i(dat0_i), .done_o(done_o), .rsp_o(rsp_o),
    .idx_err_o(idx_err_o), .crc_err_o(crc_err_o), .tmo_err_o(tmo_err_o)
  );

  function automatic logic [6:0] crc7(logic [135:0] v, int hi, int lo);
    logic [6:0] c = '0;
    for (int i = hi; i >= lo; i--) begin
      logic b = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (b) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // reference model: phase 0 idle, 1 wait, 2 shift, 3 check, 4 busy-low, 5 busy-high
  int m_ph = 0, m_w = 0, m_k = 0;
  logic [1:0] m_kind = '0;
  logic [5:0] m_idx = '0;
  logic m_ie = 0, m_ce = 0;
  logic m_done = 0, m_ierr = 0, m_cerr = 0, m_terr = 0;
  logic [135:0] m_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_ierr = 0; m_cerr = 0; m_terr = 0; m_data = '0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (issue_i) begin
          m_kind = rsp_kind_i; m_idx = cmd_idx_i; m_ie = idx_chk_i; m_ce = crc_chk_i;
          m_ierr = 0; m_cerr = 0; m_terr = 0; m_data = '0; m_w = 0;
          if (rsp_kind_i == 2'b00) m_done = 1; else m_ph = 1;
        end
        1: begin
          m_w++;
          if (cmd_line_i == 1'b0) begin
            m_data = {m_data[134:0], 1'b0}; m_k = 1; m_ph = 2;
          end else if (m_w == 64) begin
            m_terr = 1; m_done = 1; m_ph = 0;
          end
        end
        2: begin
          m_data = {m_data[134:0], cmd_line_i}; m_k++;
          if (m_k == ((m_kind == 2'b01) ? 136 : 48)) m_ph = 3;
        end
        3: begin
          if (m_kind == 2'b01) m_cerr = m_ce && (crc7(m_data, 127, 8) != m_data[7:1]);
          else begin
            m_cerr = m_ce && (crc7(m_data, 47, 8) != m_data[7:1]);
            m_ierr = m_ie && (m_data[45:40] != m_idx);
          end
          if (m_kind == 2'b11) m_ph = 4; else begin m_done = 1; m_ph = 0; end
        end
        4: if (!dat0_i) m_ph = 5;
        5: if (dat0_i) begin m_done = 1; m_ph = 0; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (done_o !== m_done) begin errors++; $display("FAIL R9 done actual %0b expected %0b", done_o, m_done); end
    if (idx_err_o !== m_ierr) begin errors++; $display("FAIL R5 idx_err actual %0b expected %0b", idx_err_o, m_ierr); end
    if (crc_err_o !== m_cerr) begin errors++; $display("FAIL R6 crc_err actual %0b expected %0b", crc_err_o, m_cerr); end
    if (tmo_err_o !== m_terr) begin errors++; $display("FAIL R7 tmo_err actual %0b expected %0b", tmo_err_o, m_terr); end
    if (rsp_o !== m_data) begin errors++; $display("FAIL R3 rsp actual %h expected %h", rsp_o, m_data); end
  end

  task automatic chk(string req, logic [135:0] act, logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [135:0] mk_short(logic [5:0] ix, logic [31:0] arg, logic bad);
    logic [135:0] f = '0;
    f[45:40] = ix;
    f[39:8]  = arg;
    f[7:1]   = crc7(f, 47, 8) ^ (bad ? 7'h01 : 7'h00);
    f[0]     = 1'b1;
    return f;
  endfunction

  function automatic logic [135:0] mk_long(logic [119:0] body, logic bad);
    logic [135:0] f = '0;
    f[135:128] = 8'h3F;
    f[127:8]   = body;
    f[7:1]     = crc7(f, 127, 8) ^ (bad ? 7'h40 : 7'h00);
    f[0]       = 1'b1;
    return f;
  endfunction

  task automatic send(logic [1:0] k, logic [5:0] ix, logic ie, logic ce);
    @(negedge clk);
    issue_i = 1'b1; rsp_kind_i = k; cmd_idx_i = ix; idx_chk_i = ie; crc_chk_i = ce;
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  task automatic drive_frame(logic [135:0] f, int len, int gap);
    for (int i = 0; i < gap; i++) begin cmd_line_i = 1'b1; @(negedge clk); end
    for (int i = len - 1; i >= 0; i--) begin cmd_line_i = f[i]; @(negedge clk); end
    cmd_line_i = 1'b1;
  endtask

  task automatic finish_expect(string req, logic ei, logic ec, logic et, logic [135:0] ed);
    int n = 0;
    while (!done_o && n < 300) begin @(negedge clk); n++; end
    chk({req, " done"}, 136'(done_o), 136'(1));
    chk("R5 idx flag", 136'(idx_err_o), 136'(ei));
    chk("R6 crc flag", 136'(crc_err_o), 136'(ec));
    chk("R7 tmo flag", 136'(tmo_err_o), 136'(et));
    chk({req, " data"}, rsp_o, ed);
    @(negedge clk);
    chk("R9 done pulse", 136'(done_o), 136'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [135:0] f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {rsp_o[131:0], done_o, idx_err_o, crc_err_o, tmo_err_o}, '0);

    // R2 no response
    send(2'b00, 6'd3, 1'b1, 1'b1);
    chk("R2 done next cycle", 136'(done_o), 136'(1));
    chk("R2 data zero", rsp_o, '0);
    @(negedge clk);
    chk("R9 pulse width", 136'(done_o), 136'(0));

    // R3 short good frame
    f = mk_short(6'd17, 32'h0000_0900, 1'b0);
    send(2'b10, 6'd17, 1'b1, 1'b1); drive_frame(f, 48, 3);
    finish_expect("R3", 0, 0, 0, f);

    // R5 index mismatch enabled then disabled
    f = mk_short(6'd9, 32'hDEAD_BEEF, 1'b0);
    send(2'b10, 6'd5, 1'b1, 1'b1); drive_frame(f, 48, 0);
    finish_expect("R5", 1, 0, 0, f);
    send(2'b10, 6'd5, 1'b0, 1'b1); drive_frame(f, 48, 2);
    finish_expect("R5", 0, 0, 0, f);

    // R6 crc mismatch enabled then disabled
    f = mk_short(6'd13, 32'h1234_5678, 1'b1);
    send(2'b10, 6'd13, 1'b1, 1'b1); drive_frame(f, 48, 5);
    finish_expect("R6", 0, 1, 0, f);
    send(2'b10, 6'd13, 1'b1, 1'b0); drive_frame(f, 48, 1);
    finish_expect("R6", 0, 0, 0, f);

    // R4 long frames
    f = mk_long(120'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_96, 1'b0);
    send(2'b01, 6'd2, 1'b1, 1'b1); drive_frame(f, 136, 4);
    finish_expect("R4", 0, 0, 0, f);
    f = mk_long(120'hFFEE_DDCC_BBAA_9988_7766_5544_3322_11, 1'b1);
    send(2'b01, 6'd9, 1'b1, 1'b1); drive_frame(f, 136, 0);
    finish_expect("R4", 0, 1, 0, f);

    // R7 timeout and the last accepted slot
    send(2'b10, 6'd1, 1'b1, 1'b1);
    cmd_line_i = 1'b1;
    finish_expect("R7", 0, 0, 1, '0);
    f = mk_short(6'd1, 32'hA5A5_5A5A, 1'b0);
    send(2'b10, 6'd1, 1'b1, 1'b1); drive_frame(f, 48, 63);
    finish_expect("R7", 0, 0, 0, f);

    // R8 busy wait, with a stray issue (R9) during busy
    f = mk_short(6'd7, 32'h0000_0000, 1'b0);
    send(2'b11, 6'd7, 1'b1, 1'b1); drive_frame(f, 48, 2);
    dat0_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i == 2) begin issue_i = 1'b1; rsp_kind_i = 2'b00; end
      else issue_i = 1'b0;
      @(negedge clk);
      chk("R8 no done while busy", 136'(done_o), 136'(0));
    end
    issue_i = 1'b0;
    dat0_i = 1'b1;
    @(negedge clk);
    chk("R8 done after release", 136'(done_o), 136'(1));
    chk("R9 data kept", rsp_o, f);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule